// File: doc/BRIEF.md
# Electrical Idle Inference Timer

This block decides that the far end of a serial link has dropped into electrical idle. It watches for an expected event and raises a flag when that event does not arrive within a time window. A 3-bit condition code picks the event and the window. A rate input picks first- or second-generation timing. An upstream decoder supplies three single-cycle strobes: a COM/SKP ordered set was seen, a TS1/TS2 ordered set was seen, or an exit from electrical idle was seen. The flag is sticky. It stays high until a watched event arrives, the condition or rate changes, or reset is applied.

Every window is a parameter counted in clock cycles. The unit-interval windows assume one clock per 10-bit symbol, which `UI_PER_CLK` sets. The microsecond windows are derived from the clock frequency at each rate (`CLK_MHZ_G1`, `CLK_MHZ_G2`). The strobes and the flag are plain control pins with no handshake. A strobe counts in the cycle it is high and has no back-pressure.

Top module: `eidle_infer_timer`

## Requirements
- R1: While `cond_sel[2]` is 0 (codes 0xx), `idle_inferred` is low one edge later and stays low, whatever the strobes do.
- R2: Code 3'b100 watches `comskp_seen` only. With no such strobe, `idle_inferred` rises on the W-th rising edge after the restart edge. W is 128*`CLK_MHZ_G1` cycles when `rate_gen2`=0 and 128*`CLK_MHZ_G2` cycles when `rate_gen2`=1.
- R3: Code 3'b101 watches `ts_seen` only. W is 1280/`UI_PER_CLK` cycles at either rate.
- R4: Code 3'b110 watches `eidle_exit_seen` only. W is 2000/`UI_PER_CLK` cycles when `rate_gen2`=0 and 16000/`UI_PER_CLK` cycles when `rate_gen2`=1.
- R5: Code 3'b111 with `rate_gen2`=0 watches `eidle_exit_seen` with W = 128*`CLK_MHZ_G1` cycles. Code 3'b111 with `rate_gen2`=1 behaves as no inference: the output is low and there is no timing.
- R6: A watched strobe sampled at an edge drives `idle_inferred` low after that edge. That edge becomes the new restart edge.
- R7: Strobes that the current code does not watch have no effect on the count or on the flag.
- R8: A change of `cond_sel` or `rate_gen2` between two edges restarts the window at the second edge and clears `idle_inferred`.
- R9: Once high, `idle_inferred` stays high while the code and rate stay the same and no watched strobe arrives.
- R10: With `rst` high at an edge, `idle_inferred` is low after that edge and the window count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 3 | Inference condition code |
| rate_gen2 | input | 1 | 1 selects second-generation timing |
| comskp_seen | input | 1 | Strobe: COM/SKP ordered set detected |
| ts_seen | input | 1 | Strobe: TS1/TS2 ordered set detected |
| eidle_exit_seen | input | 1 | Strobe: electrical idle exit detected |
| idle_inferred | output | 1 | Sticky electrical-idle inference flag |

## Verification
The restart edge is the edge that samples a code change, a rate change or a watched strobe. The flag is low right after that edge. It must still be low after W-1 further edges and high after the W-th. The bench drives inputs on falling edges and samples at the falling edge after the edge of interest. It checks both sides of every window boundary, so an off-by-one in any window is caught. Strobes that are ignored, and codes with no timing, are checked by watching the flag across the full window in which it would otherwise have changed.

// File: rtl/eidle_pkg.sv
package eidle_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_COMSKP = 2'd1,
    EV_TS     = 2'd2,
    EV_EXIT   = 2'd3
  } ev_sel_e;

  localparam logic [2:0] COND_COMSKP_US = 3'b100;
  localparam logic [2:0] COND_TS_UI     = 3'b101;
  localparam logic [2:0] COND_EXIT_UI   = 3'b110;
  localparam logic [2:0] COND_EXIT_US   = 3'b111;

  localparam int unsigned US_WINDOW   = 128;
  localparam int unsigned UI_TS       = 1280;
  localparam int unsigned UI_EXIT_G1  = 2000;
  localparam int unsigned UI_EXIT_G2  = 16000;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/eidle_mode_decode.sv
module eidle_mode_decode
  import eidle_pkg::*;
#(
  parameter int unsigned CW        = 16,
  parameter int unsigned W_US_G1   = 256,
  parameter int unsigned W_US_G2   = 512,
  parameter int unsigned W_TS      = 128,
  parameter int unsigned W_EXIT_G1 = 200,
  parameter int unsigned W_EXIT_G2 = 1600
) (
  input  logic [2:0]    cond_sel,
  input  logic          rate_gen2,
  output logic          active,
  output ev_sel_e       watch,
  output logic [CW-1:0] win
);
  always_comb begin
    active = 1'b0;
    watch  = EV_NONE;
    win    = '0;
    unique case (cond_sel)
      COND_COMSKP_US: begin
        active = 1'b1;
        watch  = EV_COMSKP;
        win    = rate_gen2 ? CW'(W_US_G2) : CW'(W_US_G1);
      end
      COND_TS_UI: begin
        active = 1'b1;
        watch  = EV_TS;
        win    = CW'(W_TS);
      end
      COND_EXIT_UI: begin
        active = 1'b1;
        watch  = EV_EXIT;
        win    = rate_gen2 ? CW'(W_EXIT_G2) : CW'(W_EXIT_G1);
      end
      COND_EXIT_US: begin
        if (!rate_gen2) begin
          active = 1'b1;
          watch  = EV_EXIT;
          win    = CW'(W_US_G1);
        end
      end
      default: begin
        active = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/eidle_change_det.sv
module eidle_change_det #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic [W-1:0] cur,
  output logic         changed
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    prev_q <= cur;
  end

  assign changed = (cur != prev_q);
endmodule

// File: rtl/eidle_window_cnt.sv
module eidle_window_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] win,
  output logic          expired
);
  logic [CW-1:0] cnt_q;
  logic          flag_q;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (cnt_q != win) begin
      cnt_q <= cnt_inc;
      if (cnt_inc == win) begin
        flag_q <= 1'b1;
      end
    end
  end

  assign expired = flag_q;
endmodule

// File: rtl/eidle_infer_timer.sv
module eidle_infer_timer
  import eidle_pkg::*;
#(
  parameter int unsigned UI_PER_CLK = 10,
  parameter int unsigned CLK_MHZ_G1 = 250,
  parameter int unsigned CLK_MHZ_G2 = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] cond_sel,
  input  logic       rate_gen2,
  input  logic       comskp_seen,
  input  logic       ts_seen,
  input  logic       eidle_exit_seen,
  output logic       idle_inferred
);
  localparam int unsigned W_US_G1   = US_WINDOW * CLK_MHZ_G1;
  localparam int unsigned W_US_G2   = US_WINDOW * CLK_MHZ_G2;
  localparam int unsigned W_TS      = UI_TS / UI_PER_CLK;
  localparam int unsigned W_EXIT_G1 = UI_EXIT_G1 / UI_PER_CLK;
  localparam int unsigned W_EXIT_G2 = UI_EXIT_G2 / UI_PER_CLK;
  localparam int unsigned W_MAX     =
    max2(max2(W_US_G1, W_US_G2), max2(W_TS, max2(W_EXIT_G1, W_EXIT_G2)));
  localparam int unsigned CW        = $clog2(W_MAX + 1);

  logic          active;
  ev_sel_e       watch;
  logic [CW-1:0] win;
  logic          changed;
  logic          hit;
  logic          restart;

  eidle_mode_decode #(
    .CW(CW), .W_US_G1(W_US_G1), .W_US_G2(W_US_G2), .W_TS(W_TS),
    .W_EXIT_G1(W_EXIT_G1), .W_EXIT_G2(W_EXIT_G2)
  ) i_decode (
    .cond_sel (cond_sel),
    .rate_gen2(rate_gen2),
    .active   (active),
    .watch    (watch),
    .win      (win)
  );

  eidle_change_det #(.W(4)) i_chg (
    .clk    (clk),
    .cur    ({cond_sel, rate_gen2}),
    .changed(changed)
  );

  always_comb begin
    unique case (watch)
      EV_COMSKP: hit = comskp_seen;
      EV_TS:     hit = ts_seen;
      EV_EXIT:   hit = eidle_exit_seen;
      default:   hit = 1'b0;
    endcase
  end

  assign restart = !active || changed || hit;

  eidle_window_cnt #(.CW(CW)) i_cnt (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .win    (win),
    .expired(idle_inferred)
  );
endmodule

// File: rtl/eidle_infer_chk.sv
module eidle_infer_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cond_sel,
  input logic       rate_gen2,
  input logic       comskp_seen,
  input logic       ts_seen,
  input logic       eidle_exit_seen,
  input logic       idle_inferred
);
  logic watched_hit;
  assign watched_hit = (cond_sel == 3'b100 && comskp_seen) ||
                       (cond_sel == 3'b101 && ts_seen) ||
                       (cond_sel == 3'b110 && eidle_exit_seen) ||
                       (cond_sel == 3'b111 && !rate_gen2 && eidle_exit_seen);

  // R1
  no_infer_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cond_sel[2] |=> !idle_inferred);

  // R5
  gen2_exit_us_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 3'b111 && rate_gen2) |=> !idle_inferred);

  // R6
  event_clears_chk: assert property (@(posedge clk) disable iff (rst)
    watched_hit |=> !idle_inferred);

  // R8
  change_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable({cond_sel, rate_gen2}) |=> !idle_inferred);

  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_inferred && $stable({cond_sel, rate_gen2}) && !watched_hit)
      |=> idle_inferred);

  // R10
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> !idle_inferred);
endmodule

bind eidle_infer_timer eidle_infer_chk i_chk (
  .clk            (clk),
  .rst            (rst),
  .cond_sel       (cond_sel),
  .rate_gen2      (rate_gen2),
  .comskp_seen    (comskp_seen),
  .ts_seen        (ts_seen),
  .eidle_exit_seen(eidle_exit_seen),
  .idle_inferred  (idle_inferred)
);

// File: tb/test_eidle_infer_timer.sv
module test_eidle_infer_timer;
  localparam int CLK_PERIOD = 10;
  localparam int UPC   = 10;
  localparam int MHZ1  = 2;
  localparam int MHZ2  = 3;
  localparam int W_US1 = 128 * MHZ1;
  localparam int W_US2 = 128 * MHZ2;
  localparam int W_TS  = 1280 / UPC;
  localparam int W_EX1 = 2000 / UPC;
  localparam int W_EX2 = 16000 / UPC;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cond_sel = 3'b000;
  logic       rate_gen2 = 1'b0;
  logic       comskp_seen = 1'b0;
  logic       ts_seen = 1'b0;
  logic       eidle_exit_seen = 1'b0;
  logic       idle_inferred;

  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eidle_infer_timer #(.UI_PER_CLK(UPC), .CLK_MHZ_G1(MHZ1), .CLK_MHZ_G2(MHZ2))
  i_eidle_infer_timer (
    .clk(clk), .rst(rst), .cond_sel(cond_sel), .rate_gen2(rate_gen2),
    .comskp_seen(comskp_seen), .ts_seen(ts_seen),
    .eidle_exit_seen(eidle_exit_seen), .idle_inferred(idle_inferred)
  );

  task automatic check(input logic exp, input string req);
    vectors++;
    if (idle_inferred !== exp) begin
      fails++;
      $display("FAIL %s: idle_inferred=%b expected=%b at %0t", req, idle_inferred, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Park on code 000, then select a code; returns at the negedge after the restart edge.
  task automatic enter(input logic [2:0] c, input logic g2);
    cond_sel = 3'b000; rate_gen2 = 1'b0;
    wait_n(2);
    cond_sel = c; rate_gen2 = g2;
    wait_n(1);
  endtask

  task automatic window(input int w, input string req);
    check(1'b0, req);
    wait_n(w - 1);
    check(1'b0, req);
    wait_n(1);
    check(1'b1, req);
  endtask

  task automatic pulse(input int which);
    if (which == 0) comskp_seen = 1'b1;
    if (which == 1) ts_seen = 1'b1;
    if (which == 2) eidle_exit_seen = 1'b1;
    wait_n(1);
    comskp_seen = 1'b0; ts_seen = 1'b0; eidle_exit_seen = 1'b0;
  endtask

  task automatic t_reset();
    wait_n(3);
    check(1'b0, "R10");
    rst = 1'b0;
    enter(3'b101, 1'b0);
    window(W_TS, "R10");
    rst = 1'b1;
    wait_n(1);
    check(1'b0, "R10");
    rst = 1'b0;
    wait_n(W_TS - 1);
    check(1'b0, "R10");
    wait_n(1);
    check(1'b1, "R10");
  endtask

  task automatic t_windows();
    enter(3'b100, 1'b0); window(W_US1, "R2");
    enter(3'b100, 1'b1); window(W_US2, "R2");
    enter(3'b101, 1'b1); window(W_TS,  "R3");
    enter(3'b110, 1'b0); window(W_EX1, "R4");
    enter(3'b110, 1'b1); window(W_EX2, "R4");
    enter(3'b111, 1'b0); window(W_US1, "R5");
  endtask

  task automatic t_inactive();
    enter(3'b011, 1'b0);
    pulse(0); pulse(1); pulse(2);
    wait_n(W_EX2 + 10);
    check(1'b0, "R1");
    enter(3'b111, 1'b1);
    wait_n(W_US1 + 10);
    check(1'b0, "R5");
  endtask

  task automatic t_reload();
    enter(3'b101, 1'b0);
    wait_n(W_TS - 10);
    pulse(1);
    window(W_TS, "R6");
    pulse(1);
    check(1'b0, "R6");
    enter(3'b110, 1'b0);
    wait_n(W_EX1 - 5);
    pulse(2);
    window(W_EX1, "R6");
  endtask

  task automatic t_ignore();
    enter(3'b101, 1'b0);
    wait_n(W_TS - 20);
    pulse(0);
    pulse(2);
    wait_n(17);
    check(1'b0, "R7");
    wait_n(1);
    check(1'b1, "R7");
    pulse(0);
    check(1'b1, "R7");
  endtask

  task automatic t_change();
    enter(3'b100, 1'b0);
    wait_n(W_US1 - 10);
    rate_gen2 = 1'b1;
    wait_n(1);
    window(W_US2, "R8");
    cond_sel = 3'b110;
    wait_n(1);
    check(1'b0, "R8");
    wait_n(W_EX2 - 1);
    check(1'b0, "R8");
    wait_n(1);
    check(1'b1, "R8");
  endtask

  task automatic t_sticky();
    enter(3'b101, 1'b0);
    window(W_TS, "R9");
    pulse(0); pulse(2);
    wait_n(500);
    check(1'b1, "R9");
  endtask

  initial begin
    wait_n(1);
    t_reset();
    t_windows();
    t_inactive();
    t_reload();
    t_ignore();
    t_change();
    t_sticky();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule